// File: doc/BRIEF.md
# Quad-Lane PSRAM Transaction Engine

This block is a four-lane serial master for pseudo-static RAM. Each transaction sends a run of nibbles to the memory and can then read a run of nibbles back. One nibble moves per SCK period over four bidirectional data lines. All traffic comes in on one word stream, shifted out most significant nibble first. A transaction starts on a fresh word. That word carries an 8-bit send count and an 8-bit receive count in its top bits, and its remaining bits hold the first nibbles to send. Nibbles read back are packed into words and presented on a one-cycle valid strobe.

The engine drives chip select, SCK, the four data outputs and one output enable per lane. Between the send and receive phases it inserts one idle SCK period. In the high half of that period it releases the lines, which allows for the one-clock lag of the memory's output. It drives the lines again in the same cycle that chip select is released. One SCK half-period lasts one clock. Clock division and the meaning of the memory's command bytes are left to the surrounding logic.

Top module: `qspi_psram_engine`

## Requirements
- R1: During reset the outputs are: cs_n high, sck low, dq_oe all ones, dq_o zero, rx_valid low.
- R2: A transaction begins by taking a new word from the stream, with cs_n high. Bits [31:24] of that word give the send count and bits [23:16] give the receive count. While tx_valid stays low, cs_n stays high and tx_ready stays high.
- R3: Each sent nibble appears on dq_o in an SCK-low cycle with cs_n low and holds through the following SCK-high cycle. SCK is never high while cs_n is high. Nibbles are taken MSB first: first from bits [15:0] of the header word, then from each later word starting at bits [31:28]. Bits left unused when a transaction ends are dropped.
- R4: A send count of 0 sends 256 nibbles.
- R5: With a receive count of zero, cs_n is low for exactly 2N+1 cycles (N = nibbles sent) and dq_oe stays all ones for the whole transaction.
- R6: With a receive count M > 0, one SCK-low cycle follows the last send. dq_oe then drops to zero on an SCK-high cycle, which is followed by one SCK-low cycle in which no nibble is captured. In total M+1 SCK-high cycles occur with dq_oe zero.
- R7: With M > 0, cs_n is low for exactly 2N+2M+3 cycles. dq_i is captured with no synchronizer, at the clock edge that ends each SCK-high cycle after the turnaround.
- R8: Read nibbles shift in from the right. Each group of 8 nibbles is presented on rx_data, first nibble in bits [31:28], with rx_valid high for one cycle.
- R9: If a transaction ends with fewer than 8 nibbles pending, they are presented right-aligned, with zeros above the last nibble in bits [3:0].
- R10: dq_oe returns to all ones in the same cycle that cs_n goes high.
- R11: If the stream runs dry during the send phase, SCK stays high and cs_n stays low until a word arrives. The cs_n-low time grows by the wait, and no nibble is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_data | input | 32 | Stream word: header and send nibbles |
| tx_valid | input | 1 | tx_data holds a word |
| tx_ready | output | 1 | Word taken when tx_valid is also high |
| rx_data | output | 32 | Packed read nibbles |
| rx_valid | output | 1 | rx_data valid for this cycle |
| cs_n | output | 1 | Memory chip select, active low |
| sck | output | 1 | Serial clock |
| dq_o | output | 4 | Data lane outputs |
| dq_oe | output | 4 | Per-lane output enable |
| dq_i | input | 4 | Data lane inputs |

## Verification
Every output is registered and follows the sequencer state. A sent nibble is visible from the first cycle of its SCK-low half, and each SCK half lasts exactly one clock. A read nibble is captured at the edge that ends its SCK-high cycle, so its rx_valid strobe appears one cycle later, in the SCK-low half that follows. The bench samples everything on the falling clock edge. Its memory model places each read nibble on dq_i at the falling edge inside the matching SCK-high cycle, and its cs_n-low counts are checked against the closed forms 2N+1 and 2N+2M+3 (plus the stall length for R11).

// File: rtl/qspi_eng_pkg.sv
package qspi_eng_pkg;

    localparam int LANES = 4;

    typedef enum logic [3:0] {
        ST_HDR_WR,
        ST_HDR_RD,
        ST_PREP,
        ST_WR_LO,
        ST_WR_HI,
        ST_DIR_CHK,
        ST_TA_HI,
        ST_TA_LO,
        ST_RD_HI,
        ST_RD_LO,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic drive;
    } pins_t;

    // Pin levels that belong to each sequencer step.
    function automatic pins_t pins_of(seq_state_e s);
        pins_t p;
        p = '{cs_n: 1'b1, sck: 1'b0, drive: 1'b1};
        case (s)
            ST_WR_LO, ST_DIR_CHK: p = '{cs_n: 1'b0, sck: 1'b0, drive: 1'b1};
            ST_WR_HI:             p = '{cs_n: 1'b0, sck: 1'b1, drive: 1'b1};
            ST_TA_HI, ST_RD_HI:   p = '{cs_n: 1'b0, sck: 1'b1, drive: 1'b0};
            ST_TA_LO, ST_RD_LO:   p = '{cs_n: 1'b0, sck: 1'b0, drive: 1'b0};
            default:              p = '{cs_n: 1'b1, sck: 1'b0, drive: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/qspi_tx_unpack.sv
module qspi_tx_unpack
    import qspi_eng_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req,
    input  logic              take_hdr,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              have,
    output logic [CNT_W-1:0]  field,
    output logic [LANES-1:0]  nib
);

    localparam int LW = $clog2(WORD_W + 1);
    localparam logic [LW-1:0] FULL   = LW'(WORD_W);
    localparam logic [LW-1:0] HDR_N  = LW'(CNT_W);
    localparam logic [LW-1:0] NIB_N  = LW'(LANES);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LW-1:0]     left;
    } osr_t;

    osr_t q, d;
    logic              empty;
    logic [WORD_W-1:0] src;
    logic [LW-1:0]     avail_bits;

    always_comb begin
        empty      = (q.left == '0);
        src        = empty ? tx_data : q.data;
        avail_bits = empty ? FULL : q.left;
        have       = !empty || tx_valid;
        tx_ready   = req && empty;
        field      = src[WORD_W-1 -: CNT_W];
        nib        = src[WORD_W-1 -: LANES];
        d          = q;
        if (flush) begin
            d.left = '0;
        end else if (req && have) begin
            if (take_hdr) begin
                d.data = src << CNT_W;
                d.left = avail_bits - HDR_N;
            end else begin
                d.data = src << LANES;
                d.left = avail_bits - NIB_N;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/qspi_rx_pack.sv
module qspi_rx_pack
    import qspi_eng_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              last,
    input  logic [LANES-1:0]  dq_i,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data
);

    localparam int NPW = WORD_W / LANES;
    localparam int CW  = $clog2(NPW + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(NPW);

    typedef struct packed {
        logic [WORD_W-1:0] isr;
        logic [CW-1:0]     cnt;
        logic              valid;
        logic [WORD_W-1:0] data;
    } isr_t;

    isr_t q, d;
    logic [WORD_W-1:0] shifted;
    logic [CW-1:0]     cnt_inc;

    always_comb begin
        shifted = {q.isr[WORD_W-LANES-1:0], dq_i};
        cnt_inc = q.cnt + CW'(1);
        d       = q;
        d.valid = 1'b0;
        if (cap) begin
            if (cnt_inc == FULL_CNT || last) begin
                d.valid = 1'b1;
                d.data  = shifted;
                d.isr   = '0;
                d.cnt   = '0;
            end else begin
                d.isr = shifted;
                d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_valid = q.valid;
    assign rx_data  = q.data;

endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
    import qspi_eng_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             have,
    input  logic [CNT_W-1:0] field,
    input  logic [LANES-1:0] nib,
    output logic             req,
    output logic             take_hdr,
    output logic             flush,
    output logic             cap,
    output logic             last,
    output logic             cs_n,
    output logic             sck,
    output logic             drive,
    output logic [LANES-1:0] dq_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] x;
        logic [CNT_W-1:0] y;
        pins_t            pins;
        logic [LANES-1:0] dq;
    } seq_t;

    localparam seq_t RESET_VAL = '{
        st:   ST_HDR_WR,
        x:    '0,
        y:    '0,
        pins: '{cs_n: 1'b1, sck: 1'b0, drive: 1'b1},
        dq:   '0
    };

    seq_t q, d;

    always_comb begin
        d        = q;
        req      = 1'b0;
        take_hdr = 1'b0;
        cap      = 1'b0;
        last     = 1'b0;
        case (q.st)
            ST_HDR_WR: begin
                req      = 1'b1;
                take_hdr = 1'b1;
                if (have) begin
                    d.x  = field;
                    d.st = ST_HDR_RD;
                end
            end
            ST_HDR_RD: begin
                req      = 1'b1;
                take_hdr = 1'b1;
                if (have) begin
                    d.y  = field;
                    d.st = ST_PREP;
                end
            end
            ST_PREP: begin
                req = 1'b1;
                if (have) begin
                    d.x  = q.x - ONE;
                    d.dq = nib;
                    d.st = ST_WR_LO;
                end
            end
            ST_WR_LO: d.st = ST_WR_HI;
            ST_WR_HI: begin
                if (q.x != '0) begin
                    req = 1'b1;
                    if (have) begin
                        d.x  = q.x - ONE;
                        d.dq = nib;
                        d.st = ST_WR_LO;
                    end
                end else begin
                    d.st = ST_DIR_CHK;
                end
            end
            ST_DIR_CHK: d.st = (q.y == '0) ? ST_HDR_WR : ST_TA_HI;
            ST_TA_HI:   d.st = ST_TA_LO;
            ST_TA_LO: begin
                d.y  = q.y - ONE;
                d.st = ST_RD_HI;
            end
            ST_RD_HI: begin
                cap  = 1'b1;
                last = (q.y == '0);
                d.st = ST_RD_LO;
            end
            ST_RD_LO: begin
                if (q.y != '0) begin
                    d.y  = q.y - ONE;
                    d.st = ST_RD_HI;
                end else begin
                    d.st = ST_FIN;
                end
            end
            ST_FIN:  d.st = ST_HDR_WR;
            default: d.st = ST_HDR_WR;
        endcase
        flush  = (d.st == ST_HDR_WR) && (q.st != ST_HDR_WR);
        d.pins = pins_of(d.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign cs_n  = q.pins.cs_n;
    assign sck   = q.pins.sck;
    assign drive = q.pins.drive;
    assign dq_o  = q.dq;

endmodule

// File: rtl/qspi_psram_engine.sv
module qspi_psram_engine
    import qspi_eng_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              cs_n,
    output logic              sck,
    output logic [3:0]        dq_o,
    output logic [3:0]        dq_oe,
    input  logic [3:0]        dq_i
);

    logic             have, req, take_hdr, flush, cap, last, drive;
    logic [CNT_W-1:0] field;
    logic [LANES-1:0] nib;

    qspi_tx_unpack #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .req      (req),
        .take_hdr (take_hdr),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .have     (have),
        .field    (field),
        .nib      (nib)
    );

    qspi_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .have     (have),
        .field    (field),
        .nib      (nib),
        .req      (req),
        .take_hdr (take_hdr),
        .flush    (flush),
        .cap      (cap),
        .last     (last),
        .cs_n     (cs_n),
        .sck      (sck),
        .drive    (drive),
        .dq_o     (dq_o)
    );

    qspi_rx_pack #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .last     (last),
        .dq_i     (dq_i),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

    // One enable per lane, all following the sequencer's direction flag.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_oe
        assign dq_oe[g] = drive;
    end

endmodule

// File: rtl/qspi_psram_engine_chk.sv
module qspi_psram_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic [3:0] dq_o,
    input logic [3:0] dq_oe,
    input logic       rx_valid
);

    a_r3_sck_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    a_r3_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(dq_o));

    a_r6_lanes_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 4'h0) || (dq_oe == 4'hF));

    a_r6_release_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe[0]) |-> (sck && !$past(sck) && !$past(cs_n)));

    a_r7_input_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 4'h0) |-> !cs_n);

    a_r8_push_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (dq_oe == 4'h0 && !cs_n && !sck));

    a_r10_drive_with_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (dq_oe == 4'hF));

    a_r10_regain_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[0]) |-> $rose(cs_n));

endmodule

bind qspi_psram_engine qspi_psram_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe),
    .rx_valid (rx_valid)
);

// File: tb/tb_qspi_psram_engine.sv
module tb_qspi_psram_engine;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready;
    logic [W-1:0] rx_data;
    logic         rx_valid;
    logic         cs_n, sck;
    logic [3:0]   dq_o, dq_oe;
    logic [3:0]   dq_i = 4'h0;

    always #5 clk = ~clk;

    qspi_psram_engine dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .cs_n(cs_n), .sck(sck), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
    );

    int n_chk = 0, n_fail = 0;
    bit all_done = 0;

    logic [W-1:0] txm [0:63];
    int  tx_len = 0, tx_idx = 0, hold = 0, cur_seed = 0;
    bit  pend = 0;

    logic [3:0]   wr_got [0:511];
    logic [W-1:0] rx_got [0:63];
    int  wr_n = 0, rd_hi_n = 0, cs_low = 0, rx_n = 0, n_done = 0;
    int  hi_run = 0, max_hi_run = 0;
    bit  oe_low_seen = 0;
    logic [3:0] end_oe = 4'h0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;

    function automatic logic [3:0] wnib(int sd, int k);
        return 4'((k * 7 + sd * 3 + 2) % 16);
    endfunction

    function automatic logic [3:0] rnib(int sd, int j);
        return 4'((j * 11 + sd + 5) % 16);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model, stream driver and monitors, all on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && prev_cs) begin
                cs_low = 1; wr_n = 0; rd_hi_n = 0; rx_n = 0;
                oe_low_seen = 0; max_hi_run = 0; hi_run = 0; dq_i = 4'h0;
            end else if (!cs_n) begin
                cs_low++;
            end
            if (dq_oe != 4'hF) oe_low_seen = 1;
            if (sck && !prev_sck) begin
                if (dq_oe == 4'hF) begin
                    if (wr_n < 512) wr_got[wr_n] = dq_o;
                    wr_n++;
                end else begin
                    rd_hi_n++;
                    if (rd_hi_n >= 2) dq_i = rnib(cur_seed, rd_hi_n - 2);
                end
            end
            if (sck) begin
                hi_run++;
                if (hi_run > max_hi_run) max_hi_run = hi_run;
            end else begin
                hi_run = 0;
            end
            if (rx_valid) begin
                if (rx_n < 64) rx_got[rx_n] = rx_data;
                rx_n++;
            end
            if (cs_n && !prev_cs) begin
                end_oe = dq_oe;
                n_done++;
            end
            prev_sck = sck;
            prev_cs  = cs_n;
            if (pend) tx_idx++;
            if (tx_idx == 1 && hold > 0) begin
                tx_valid = 1'b0;
                hold--;
            end else begin
                tx_valid = (tx_idx < tx_len);
            end
            tx_data = txm[tx_idx % 64];
            pend = tx_valid && tx_ready;
        end
    end

    task automatic run_txn(input int nwr, input int nrd, input int sd, input int hcy);
        int total, words, wi, top, target, exp_cs, bad, nrx;
        logic [3:0] got_b, exp_b;
        total = (nwr == 0) ? 256 : nwr;
        for (int i = 0; i < 64; i++) txm[i] = {(W/4){4'hA}};
        txm[0][31:24] = 8'(nwr);
        txm[0][23:16] = 8'(nrd);
        for (int p = 0; p < total; p++) begin
            if (p < 4) begin
                wi = 0; top = 15 - 4 * p;
            end else begin
                wi = 1 + (p - 4) / 8; top = 31 - 4 * ((p - 4) % 8);
            end
            txm[wi][top -: 4] = wnib(sd, p);
        end
        words = (total <= 4) ? 1 : 1 + ((total - 4) + 7) / 8;
        target = n_done + 1;
        @(posedge clk); #2;
        cur_seed = sd; hold = hcy; tx_idx = 0; tx_len = words;
        wait (n_done == target);
        @(posedge clk); #2;
        // R3 R4: nibble count and order
        chk(wr_n == total, (nwr == 0) ? "R4 send count" : "R3 send count", wr_n, total);
        bad = 0; got_b = 4'h0; exp_b = 4'h0;
        for (int p = 0; p < total && p < 512; p++) begin
            if (bad == 0 && wr_got[p] != wnib(sd, p)) begin
                bad = 1; got_b = wr_got[p]; exp_b = wnib(sd, p);
            end
        end
        chk(bad == 0, "R3 nibble order", got_b, exp_b);
        exp_cs = (nrd == 0) ? 2 * total + 1 : 2 * total + 2 * nrd + 3;
        if (hcy > 0) exp_cs = exp_cs + hcy - 9;
        chk(cs_low == exp_cs, (hcy > 0) ? "R11 cs low time" :
            ((nrd == 0) ? "R5 cs low time" : "R7 cs low time"), cs_low, exp_cs);
        if (nrd == 0) chk(!oe_low_seen, "R5 no turnaround", oe_low_seen, 0);
        else          chk(rd_hi_n == nrd + 1, "R6 released high phases", rd_hi_n, nrd + 1);
        chk(end_oe == 4'hF, "R10 drive at release", end_oe, 4'hF);
        nrx = (nrd + 7) / 8;
        chk(rx_n == nrx, "R8 word count", rx_n, nrx);
        for (int i = 0; i < nrx && i < rx_n; i++) begin
            logic [W-1:0] e;
            e = '0;
            for (int j = i * 8; j < nrd && j < i * 8 + 8; j++) e = {e[W-5:0], rnib(sd, j)};
            chk(rx_got[i] == e, (nrd - i * 8 < 8) ? "R9 partial word" : "R8 full word",
                rx_got[i], e);
        end
        if (hcy > 0) chk(max_hi_run == hcy - 8, "R11 sck held high", max_hi_run, hcy - 8);
    endtask

    initial begin
        int hi_cnt, rdy_cnt;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(dq_oe == 4'hF, "R1 dq_oe", dq_oe, 4'hF);
        chk(dq_o == 4'h0, "R1 dq_o", dq_o, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        hi_cnt = 0; rdy_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (cs_n && !sck) hi_cnt++;
            if (tx_ready) rdy_cnt++;
        end
        chk(hi_cnt == 20, "R2 idle cs high", hi_cnt, 20);
        chk(rdy_cnt == 20, "R2 header request", rdy_cnt, 20);
        for (int nw = 1; nw <= 9; nw++)
            for (int nr = 0; nr <= 9; nr++)
                run_txn(nw, nr, nw * 10 + nr, 0);
        run_txn(0, 3, 7, 0);
        run_txn(0, 0, 9, 0);
        run_txn(2, 16, 5, 0);
        run_txn(12, 5, 3, 20);
        run_txn(5, 21, 11, 0);
        all_done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

endmodule